// File: doc/BRIEF.md
# SCSI Controller Host Register Interface

This block is the processor-facing front end of a small SCSI bus controller. A host reaches it through a 3-bit address, a chip select, and separate read and write strobes. A DMA acknowledge line lets a DMA engine write data without the chip select. At several addresses a read and a write reach different things. A read may show a live bus view, a status byte or a latched byte. A write may load a register, or it may only fire a one-cycle command pulse toward the DMA and status logic that sits around this block.

The data path is transparent. Bytes written by the host leave on the active-low SCSI data lines unchanged. Bytes on the bus are inverted back to true polarity before the host sees them. Odd parity over a data byte can be checked when the host reads the live bus. A mismatch leaves a sticky error flag. That flag and an interrupt flag are both cleared by reading the top address.

The host strobes are asynchronous to the block clock. They pass through a synchronizer of `SYNC_STAGES` flops. Every side effect (register load, command pulse, parity check, flag clear) happens once, on the clock edge that follows the moment the synchronized strobe turns active. With the default of two stages, that is the third rising edge after the strobe rises.

Top module: `scsi_host_regif`

## Requirements
- R1: After reset, the initiator command, mode, target command, select enable, output data and input latch registers read as zero. `par_err`, `irq_flag`, `db_oe` and all four command pulses are low.
- R2: A read at address 0 returns the bitwise inverse of `bus_db_n`, with bit 0 taken from line 0. Nothing is latched, so `rdata` follows the bus while the read is held.
- R3: Addresses 1, 2 and 3 are read/write storage for the initiator command, mode and target command bytes. Each is also presented on its own output. A write at address 4 loads `sel_en`. A read at address 4 returns the `bus_stat` input.
- R4: A host write at address 0 (`cs` and `wr`) loads the output data register. So does a DMA write (`dack` and `wr` with `cs` low), whatever the address. `db_out_n` carries the inverse of that register. `db_oe` is high exactly when bit 0 of the initiator command register is set.
- R5: When bit 5 of the mode register is set, each read access at address 0 checks odd parity over the true data byte and the true parity bit, where the true parity bit is the inverse of `bus_par_n`. An even count of ones sets the sticky `par_err`. With mode bit 5 clear, no error is recorded.
- R6: A write at address 5 pulses `go_send`, at address 6 pulses `go_trecv`, and at address 7 pulses `go_irecv`. Each pulse lasts one cycle. None of these writes changes any stored register.
- R7: A read at address 7 pulses `clr_pi` for one cycle and clears both `par_err` and `irq_flag`. If `irq_set` is high on that same edge, the clear wins.
- R8: Each access produces exactly one pulse or side effect, however long its strobe is held. A new access needs the strobe to drop and rise again.
- R9: A one-cycle `irq_set` sets the sticky `irq_flag`. A read at address 5 returns `{irq_flag, par_err, aux_stat[5:0]}`, with `irq_flag` in bit 7.
- R10: `in_cap` high on a clock edge captures the inverse of `bus_db_n` into the input latch. A read at address 6 returns that latch, and the latch holds its value while the bus changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Host chip select, active high, asynchronous |
| rd | input | 1 | Host read strobe, active high, asynchronous |
| wr | input | 1 | Host or DMA write strobe, active high, asynchronous |
| dack | input | 1 | DMA acknowledge, active high, asynchronous |
| addr | input | 3 | Register address, stable while a strobe is active |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data for the current address |
| bus_db_n | input | 8 | Live SCSI data lines, active low |
| bus_par_n | input | 1 | Live SCSI parity line, active low |
| bus_stat | input | 8 | Current bus status byte, returned at address 4 |
| aux_stat | input | 6 | Low status bits, returned at address 5 |
| in_cap | input | 1 | Capture strobe for the input latch, synchronous |
| irq_set | input | 1 | Sets the interrupt flag, synchronous |
| db_out_n | output | 8 | Output data register, driven active low |
| db_oe | output | 1 | Output enable for the data lines |
| icmd | output | 8 | Initiator command register |
| mode | output | 8 | Mode register |
| tcmd | output | 8 | Target command register |
| sel_en | output | 8 | Select enable register |
| irq_flag | output | 1 | Sticky interrupt flag |
| par_err | output | 1 | Sticky parity error flag |
| go_send | output | 1 | One-cycle start DMA send pulse |
| go_trecv | output | 1 | One-cycle start DMA target receive pulse |
| go_irecv | output | 1 | One-cycle start DMA initiator receive pulse |
| clr_pi | output | 1 | One-cycle parity/interrupt clear pulse |

## Verification
The bench builds the block with its defaults: an 8-bit data path and a two-stage strobe synchronizer. This lets every one of the eight addresses be reached in both directions. It also lets the fixed bit positions be checked directly: the parity enable in mode bit 5, the drive enable in command bit 0, and the flags in bits 7 and 6 of the status byte. Strobes are held for up to twenty cycles, well beyond the three-edge synchronizer latency, to show that a long access still fires only once. Parity is exercised with matching and mismatching parity lines, both with checking enabled and with it disabled.

// File: rtl/scsi_regif_pkg.sv
// Package: shared constants and types for the SCSI host register interface.
// Assumes an 8-location register space; the address values are behavioural.
package scsi_regif_pkg;

    localparam int DATA_W      = 8;
    localparam int ADDR_W      = 3;
    localparam int MODE_PAR_EN = 5;   // mode bit that enables the parity check
    localparam int ICMD_DRIVE  = 0;   // initiator command bit that enables drive

    typedef enum logic [ADDR_W-1:0] {
        A_DATA  = 3'd0,   // rd: live bus        wr: output data
        A_ICMD  = 3'd1,   // rd/wr: initiator command
        A_MODE  = 3'd2,   // rd/wr: mode
        A_TCMD  = 3'd3,   // rd/wr: target command
        A_STAT  = 3'd4,   // rd: bus status      wr: select enable
        A_BSTAT = 3'd5,   // rd: bus and status  wr: start send
        A_INDAT = 3'd6,   // rd: input latch     wr: start target receive
        A_CLR   = 3'd7    // rd: clear flags     wr: start initiator receive
    } reg_addr_e;

    // One clock-wide access events, already synchronised and edge-detected.
    typedef struct packed {
        logic rd;       // host read became active
        logic wr_cpu;   // host write (chip select) became active
        logic wr_dma;   // DMA write (acknowledge, no chip select) became active
    } host_ev_t;

endpackage

// File: rtl/hri_sync.sv
// Module: hri_sync
// Purpose: brings asynchronous host strobes into the clock domain through
// a chain of STAGES flops per bit.
// Assumes: each strobe is glitch free and held for more than STAGES+1 cycles.
module hri_sync #(
    parameter int STAGES = 2,
    parameter int W      = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] stg [STAGES];

    // Shift each strobe through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= async_in;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign sync_out = stg[LAST];
endmodule

// File: rtl/hri_parity.sv
// Module: hri_parity
// Purpose: flags a parity mismatch on a true-polarity data byte and parity bit.
// Assumes: inputs are already inverted from the active-low bus; ODD picks the sense.
module hri_parity #(
    parameter int W   = 8,
    parameter bit ODD = 1'b1
) (
    input  logic [W-1:0] data,
    input  logic         par,
    output logic         bad
);
    generate
        if (ODD) begin : g_odd
            // Odd sense: an even number of ones across data and parity is an error.
            always_comb bad = ~(^{data, par});
        end else begin : g_even
            // Even sense: an odd number of ones is an error.
            always_comb bad = ^{data, par};
        end
    endgenerate
endmodule

// File: rtl/hri_regbank.sv
// Module: hri_regbank
// Purpose: register storage, sticky flags and command pulses, updated on
// one-cycle access events from the strobe front end.
// Assumes: addr and wdata are stable on the edge where an event is high.
module hri_regbank
    import scsi_regif_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  host_ev_t          ev,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic [DW-1:0]     bus_true,
    input  logic              par_bad,
    input  logic              in_cap,
    input  logic              irq_set,
    output logic [DW-1:0]     icmd_q,
    output logic [DW-1:0]     mode_q,
    output logic [DW-1:0]     tcmd_q,
    output logic [DW-1:0]     selen_q,
    output logic [DW-1:0]     odr_q,
    output logic [DW-1:0]     in_q,
    output logic              par_err_q,
    output logic              irq_q,
    output logic              send_p,
    output logic              trecv_p,
    output logic              irecv_p,
    output logic              clr_p
);
    logic clr_now;
    logic par_hit;

    // Decode the flag clear and the parity capture for this edge.
    always_comb begin
        clr_now = ev.rd && (addr == A_CLR);
        par_hit = ev.rd && (addr == A_DATA) && mode_q[MODE_PAR_EN] && par_bad;
    end

    // Load the host-writable registers on a write event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            icmd_q  <= '0;
            mode_q  <= '0;
            tcmd_q  <= '0;
            selen_q <= '0;
            odr_q   <= '0;
        end else if (ev.wr_cpu) begin
            case (addr)
                A_DATA:  odr_q   <= wdata;
                A_ICMD:  icmd_q  <= wdata;
                A_MODE:  mode_q  <= wdata;
                A_TCMD:  tcmd_q  <= wdata;
                A_STAT:  selen_q <= wdata;
                default: ;
            endcase
        end else if (ev.wr_dma) begin
            odr_q <= wdata;
        end
    end

    // Raise a one-cycle command pulse for strobe-only addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            send_p  <= 1'b0;
            trecv_p <= 1'b0;
            irecv_p <= 1'b0;
            clr_p   <= 1'b0;
        end else begin
            send_p  <= ev.wr_cpu && (addr == A_BSTAT);
            trecv_p <= ev.wr_cpu && (addr == A_INDAT);
            irecv_p <= ev.wr_cpu && (addr == A_CLR);
            clr_p   <= clr_now;
        end
    end

    // Keep the sticky flags; a clear takes priority over a set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_err_q <= 1'b0;
            irq_q     <= 1'b0;
        end else if (clr_now) begin
            par_err_q <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            if (par_hit) par_err_q <= 1'b1;
            if (irq_set) irq_q     <= 1'b1;
        end
    end

    // Capture the true-polarity bus byte into the input latch.
    always_ff @(posedge clk) begin
        if (!rst_n)      in_q <= '0;
        else if (in_cap) in_q <= bus_true;
    end
endmodule

// File: rtl/scsi_host_regif.sv
// Module: scsi_host_regif
// Purpose: host register decoder and data path of a SCSI bus controller.
// Reads and writes at one address reach different registers; some accesses
// only fire command pulses. Bus lines are active low and inverted here.
// Assumes: addr, wdata and cs settle before rd/wr rise and stay until they fall.
module scsi_host_regif
    import scsi_regif_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DW          = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic              dack,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [DW-1:0]     bus_db_n,
    input  logic              bus_par_n,
    input  logic [DW-1:0]     bus_stat,
    input  logic [DW-3:0]     aux_stat,
    input  logic              in_cap,
    input  logic              irq_set,
    output logic [DW-1:0]     db_out_n,
    output logic              db_oe,
    output logic [DW-1:0]     icmd,
    output logic [DW-1:0]     mode,
    output logic [DW-1:0]     tcmd,
    output logic [DW-1:0]     sel_en,
    output logic              irq_flag,
    output logic              par_err,
    output logic              go_send,
    output logic              go_trecv,
    output logic              go_irecv,
    output logic              clr_pi
);
    localparam int NSTB = 4;

    logic [NSTB-1:0] stb_s;
    logic            s_cs, s_rd, s_wr, s_dack;
    logic            rd_lvl, wr_lvl, rd_prev, wr_prev;
    host_ev_t        ev;
    logic [DW-1:0]   bus_true;
    logic            par_bad;
    logic [DW-1:0]   odr_q, in_q;

    hri_sync #(.STAGES(SYNC_STAGES), .W(NSTB)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({dack, wr, rd, cs}),
        .sync_out (stb_s)
    );

    // Split the synchronised strobes and form the access levels.
    always_comb begin
        {s_dack, s_wr, s_rd, s_cs} = stb_s;
        rd_lvl = s_cs && s_rd;
        wr_lvl = s_wr && (s_cs || s_dack);
    end

    // Remember the previous access levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_prev <= 1'b0;
            wr_prev <= 1'b0;
        end else begin
            rd_prev <= rd_lvl;
            wr_prev <= wr_lvl;
        end
    end

    // Turn rising access levels into one-cycle events.
    always_comb begin
        ev.rd     = rd_lvl && !rd_prev;
        ev.wr_cpu = wr_lvl && !wr_prev && s_cs;
        ev.wr_dma = wr_lvl && !wr_prev && !s_cs;
    end

    assign bus_true = ~bus_db_n;

    hri_parity #(.W(DW), .ODD(1'b1)) u_par (
        .data (bus_true),
        .par  (~bus_par_n),
        .bad  (par_bad)
    );

    hri_regbank #(.DW(DW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .addr      (addr),
        .wdata     (wdata),
        .bus_true  (bus_true),
        .par_bad   (par_bad),
        .in_cap    (in_cap),
        .irq_set   (irq_set),
        .icmd_q    (icmd),
        .mode_q    (mode),
        .tcmd_q    (tcmd),
        .selen_q   (sel_en),
        .odr_q     (odr_q),
        .in_q      (in_q),
        .par_err_q (par_err),
        .irq_q     (irq_flag),
        .send_p    (go_send),
        .trecv_p   (go_trecv),
        .irecv_p   (go_irecv),
        .clr_p     (clr_pi)
    );

    // Drive the bus side of the output register.
    always_comb begin
        db_out_n = ~odr_q;
        db_oe    = icmd[ICMD_DRIVE];
    end

    // Select the read data for the current address.
    always_comb begin
        case (addr)
            A_DATA:  rdata = bus_true;
            A_ICMD:  rdata = icmd;
            A_MODE:  rdata = mode;
            A_TCMD:  rdata = tcmd;
            A_STAT:  rdata = bus_stat;
            A_BSTAT: rdata = {irq_flag, par_err, aux_stat};
            A_INDAT: rdata = in_q;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/hri_checks.sv
// Module: hri_checks
// Purpose: temporal checks on the pulses and sticky flags of scsi_host_regif.
// Assumes: attached by the bind below; reset is synchronous active low.
module hri_checks (
    input logic clk,
    input logic rst_n,
    input logic go_send,
    input logic go_trecv,
    input logic go_irecv,
    input logic clr_pi,
    input logic par_err,
    input logic irq_flag
);
    // R6: command pulses never last longer than one cycle.
    p_send_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        go_send |=> !go_send);
    p_trecv_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        go_trecv |=> !go_trecv);
    p_irecv_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        go_irecv |=> !go_irecv);

    // R8: a single access never fires two different pulses together.
    p_pulse_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({go_send, go_trecv, go_irecv, clr_pi}));

    // R7: the clear pulse leaves both flags low, even against a same-edge set.
    p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pi |-> (!par_err && !irq_flag));

    // R5: the parity error flag only drops with the clear pulse.
    p_par_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |=> (par_err || clr_pi));

    // R9: the interrupt flag only drops with the clear pulse.
    p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag |=> (irq_flag || clr_pi));
endmodule

bind scsi_host_regif hri_checks u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_send  (go_send),
    .go_trecv (go_trecv),
    .go_irecv (go_irecv),
    .clr_pi   (clr_pi),
    .par_err  (par_err),
    .irq_flag (irq_flag)
);

// File: tb/sim_scsi_host_regif.sv
// Directed bench for scsi_host_regif: one task per scenario, each self-checking.
module sim_scsi_host_regif;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 0, rd = 0, wr = 0, dack = 0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] bus_db_n = 8'hFF;
    logic       bus_par_n = 1'b1;
    logic [7:0] bus_stat = '0;
    logic [5:0] aux_stat = '0;
    logic       in_cap = 0, irq_set = 0;
    logic [7:0] db_out_n, icmd, mode, tcmd, sel_en;
    logic       db_oe, irq_flag, par_err, go_send, go_trecv, go_irecv, clr_pi;

    int n_chk = 0, n_fail = 0;
    int c_send = 0, c_trecv = 0, c_irecv = 0, c_clr = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    scsi_host_regif u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .dack(dack),
        .addr(addr), .wdata(wdata), .rdata(rdata), .bus_db_n(bus_db_n),
        .bus_par_n(bus_par_n), .bus_stat(bus_stat), .aux_stat(aux_stat),
        .in_cap(in_cap), .irq_set(irq_set), .db_out_n(db_out_n), .db_oe(db_oe),
        .icmd(icmd), .mode(mode), .tcmd(tcmd), .sel_en(sel_en),
        .irq_flag(irq_flag), .par_err(par_err), .go_send(go_send),
        .go_trecv(go_trecv), .go_irecv(go_irecv), .clr_pi(clr_pi)
    );

    // Count pulse cycles away from the active edge.
    always @(negedge clk) begin
        if (go_send)  c_send++;
        if (go_trecv) c_trecv++;
        if (go_irecv) c_irecv++;
        if (clr_pi)   c_clr++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [2:0] a, input logic [7:0] d,
                              input bit use_dma, input int hold);
        @(negedge clk);
        addr = a; wdata = d;
        if (use_dma) dack = 1; else cs = 1;
        @(negedge clk); wr = 1;
        repeat (hold) @(negedge clk);
        wr = 0;
        @(negedge clk); cs = 0; dack = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic read_begin(input logic [2:0] a);
        @(negedge clk); addr = a; cs = 1;
        @(negedge clk); rd = 1;
        @(negedge clk);
    endtask

    task automatic read_end(input int hold);
        repeat (hold) @(negedge clk);
        rd = 0;
        @(negedge clk); cs = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic host_read(input logic [2:0] a, output logic [7:0] d);
        read_begin(a);
        d = rdata;
        read_end(5);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk(icmd == 0 && mode == 0 && tcmd == 0 && sel_en == 0, "R1 regs", {icmd, mode}, 0);
        chk(db_out_n == 8'hFF && !db_oe, "R1 drive", {db_oe, db_out_n}, 8'hFF);
        chk(!par_err && !irq_flag, "R1 flags", {par_err, irq_flag}, 0);
        chk(!go_send && !go_trecv && !go_irecv && !clr_pi, "R1 pulses",
            {go_send, go_trecv, go_irecv, clr_pi}, 0);
        host_read(3'd6, v);
        chk(v == 8'h00, "R1 input latch", v, 0);
    endtask

    task automatic t_live_bus;
        bus_db_n = 8'hA5;
        read_begin(3'd0);
        chk(rdata == 8'h5A, "R2 live read", rdata, 8'h5A);
        bus_db_n = 8'hFE;
        @(negedge clk);
        chk(rdata == 8'h01, "R2 no latching, bit0", rdata, 8'h01);
        read_end(4);
    endtask

    task automatic t_plain_regs;
        logic [7:0] v;
        host_write(3'd1, 8'h3C, 0, 5);
        host_write(3'd2, 8'hC3, 0, 5);
        host_write(3'd3, 8'hFF, 0, 5);
        host_read(3'd1, v); chk(v == 8'h3C, "R3 icmd readback", v, 8'h3C);
        host_read(3'd2, v); chk(v == 8'hC3, "R3 mode readback", v, 8'hC3);
        host_read(3'd3, v); chk(v == 8'hFF && tcmd == 8'hFF, "R3 tcmd readback", v, 8'hFF);
        bus_stat = 8'h42;
        host_write(3'd4, 8'h81, 0, 5);
        chk(sel_en == 8'h81, "R3 select enable", sel_en, 8'h81);
        host_read(3'd4, v); chk(v == 8'h42, "R3 status read", v, 8'h42);
    endtask

    task automatic t_output_data;
        host_write(3'd1, 8'h00, 0, 5);
        host_write(3'd0, 8'h96, 0, 5);
        chk(db_out_n == 8'h69 && !db_oe, "R4 host load, undriven", {db_oe, db_out_n}, 8'h69);
        host_write(3'd1, 8'h01, 0, 5);
        chk(db_oe, "R4 drive enable", db_oe, 1);
        host_write(3'd3, 8'h11, 1, 5);
        chk(db_out_n == 8'hEE, "R4 DMA load", db_out_n, 8'hEE);
        chk(tcmd == 8'hFF, "R4 DMA leaves tcmd", tcmd, 8'hFF);
    endtask

    task automatic t_parity;
        logic [7:0] v;
        host_write(3'd2, 8'h20, 0, 5);
        bus_db_n = 8'hFE; bus_par_n = 1'b1;      // data 0x01, parity 0: odd, good
        host_read(3'd0, v);
        chk(!par_err, "R5 good parity", par_err, 0);
        bus_par_n = 1'b0;                        // parity 1: even, bad
        host_read(3'd0, v);
        chk(par_err, "R5 bad parity sets flag", par_err, 1);
        host_read(3'd5, v);
        chk(v[6] == 1'b1, "R5 flag in status bit 6", v[6], 1);
    endtask

    task automatic t_clear;
        int c0;
        logic [7:0] v;
        c0 = c_clr;
        host_read(3'd7, v);
        chk(c_clr - c0 == 1, "R7 clear pulse", c_clr - c0, 1);
        chk(!par_err, "R7 parity flag cleared", par_err, 0);
        host_write(3'd2, 8'h00, 0, 5);
        host_read(3'd0, v);                      // still bad parity, check off
        chk(!par_err, "R5 disabled check", par_err, 0);
        bus_par_n = 1'b1;
    endtask

    task automatic t_irq;
        logic [7:0] v;
        aux_stat = 6'h15;
        @(negedge clk); irq_set = 1;
        @(negedge clk); irq_set = 0;
        chk(irq_flag, "R9 irq set", irq_flag, 1);
        host_read(3'd5, v);
        chk(v == 8'h95, "R9 bus and status", v, 8'h95);
        host_read(3'd7, v);
        chk(!irq_flag, "R7 irq cleared", irq_flag, 0);
    endtask

    task automatic t_pulses;
        int s0, t0, i0, k0;
        logic [7:0] v;
        host_write(3'd1, 8'h5A, 0, 5);
        host_write(3'd2, 8'hA4, 0, 5);
        host_write(3'd0, 8'h33, 0, 5);
        s0 = c_send; t0 = c_trecv; i0 = c_irecv; k0 = c_clr;
        host_write(3'd5, 8'hFF, 0, 20);
        chk(c_send - s0 == 1 && c_trecv == t0 && c_irecv == i0, "R8 send once", c_send - s0, 1);
        host_write(3'd6, 8'hFF, 0, 20);
        chk(c_trecv - t0 == 1, "R6 target receive pulse", c_trecv - t0, 1);
        host_write(3'd7, 8'hFF, 0, 20);
        chk(c_irecv - i0 == 1 && c_clr == k0, "R6 initiator receive pulse", c_irecv - i0, 1);
        host_write(3'd5, 8'h00, 0, 3);
        host_write(3'd5, 8'h00, 0, 3);
        chk(c_send - s0 == 3, "R8 re-armed strobe", c_send - s0, 3);
        chk(icmd == 8'h5A && mode == 8'hA4 && tcmd == 8'hFF && sel_en == 8'h81,
            "R6 no storage change", {icmd, mode}, 16'h5AA4);
        chk(db_out_n == 8'hCC, "R6 output data kept", db_out_n, 8'hCC);
        read_begin(3'd7);
        read_end(20);
        chk(c_clr - k0 == 1, "R8 long read clears once", c_clr - k0, 1);
        host_read(3'd2, v);
        chk(v == 8'hA4, "R6 mode readback", v, 8'hA4);
    endtask

    task automatic t_in_latch;
        logic [7:0] v;
        bus_db_n = 8'h81;                        // true 0x7E
        @(negedge clk); in_cap = 1;
        @(negedge clk); in_cap = 0;
        bus_db_n = 8'h00;
        host_read(3'd6, v);
        chk(v == 8'h7E, "R10 latch holds", v, 8'h7E);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_live_bus();
        t_plain_regs();
        t_output_data();
        t_parity();
        t_clear();
        t_irq();
        t_pulses();
        t_in_latch();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule